// File: doc/BRIEF.md
# Block-Protocol Frame Receiver

This block sits behind a byte-wide UART on the card side of a half-duplex, block-oriented transmission link. A frame-start strobe opens a new block. The block then takes bytes from a valid-qualified stream and reads the three-byte prologue: node address, protocol control byte and length. It forwards the information field byte by byte. It checks the trailer against a running error-detection code.

The trailer is either a one-byte XOR longitudinal check or a two-byte CRC-16. The choice is made at run time. When a block closes, a one-cycle status pulse reports the result and the block type decoded from the control byte. The result is good, a bad check code, or a length that cannot be accepted.

Top module: `tblk_receiver`

## Requirements
- R1: After reset, node_addr, ctrl_byte, blk_kind, info_valid, info_byte, done_pulse and done_status are all zero.
- R2: Bytes presented before the first frame_start, and after a block has closed, produce no info_valid and no done_pulse, and leave node_addr and ctrl_byte unchanged.
- R3: After frame_start, the first accepted byte appears on node_addr and the second on ctrl_byte. Each appears one cycle after the byte is taken, and each holds until the same position in the next block.
- R4: blk_kind decodes ctrl_byte. Bit 7 = 0 gives 2'b00 (data block). Bits 7:6 = 10 give 2'b10 (acknowledge block). Bits 7:6 = 11 give 2'b11 (control block).
- R5: The third byte is the length L. The next L accepted bytes are each presented on info_byte with a one-cycle info_valid, one cycle after acceptance, in arrival order.
- R6: With the mode latched as 0 (XOR mode), exactly one trailer byte follows the information field. done_status is 2'b00 when that byte equals the XOR of all bytes from the node address through the last information byte. Otherwise done_status is 2'b01.
- R7: With the mode latched as 1 (CRC mode), two trailer bytes follow, high byte first. They are compared with a CRC computed MSB-first with polynomial 0x1021 and start value 0xFFFF, over the node address through the last information byte. done_status is 2'b00 when both bytes match and 2'b01 when either differs.
- R8: A length byte above MAX_INFO closes the block at once with done_status 2'b10 and forwards no information bytes. A length of 255 is always rejected. Bytes after a rejected length are ignored until the next frame_start.
- R9: done_pulse is high for exactly one cycle per closed block, one cycle after its final byte is taken. During that cycle, blk_kind gives the type of that block.
- R10: frame_start abandons any block in progress without a done_pulse. It latches edc_sel as the trailer mode for the new block. Later changes of edc_sel have no effect until the next frame_start. A byte offered in the same cycle as frame_start is ignored.
- R11: A length of zero goes straight to the trailer, with no info_valid.
- R12: Cycles with in_valid low leave the parse position and the check code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Opens a new block and latches the trailer mode |
| edc_sel | input | 1 | Trailer mode: 0 = XOR byte, 1 = CRC-16 |
| in_valid | input | 1 | in_byte holds a received byte |
| in_byte | input | 8 | Received byte |
| node_addr | output | 8 | Node address of the current block |
| ctrl_byte | output | 8 | Protocol control byte of the current block |
| blk_kind | output | 2 | Decoded block type |
| info_valid | output | 1 | info_byte holds an information byte |
| info_byte | output | 8 | Forwarded information byte |
| done_pulse | output | 1 | One-cycle end-of-block strobe |
| done_status | output | 2 | 00 good, 01 bad check code, 10 bad length |

## Verification
The bench builds the receiver with MAX_INFO set to 16, which keeps the polynomial and start value at their defaults. This places the accept and reject boundary for the length field at 16 and 17. Blocks short enough to run many times can then exercise both sides of it, next to the fixed rejection of 255. The CRC mode runs on the same short blocks, with faults placed in the high and low trailer bytes separately. Mid-block aborts, idle gaps and a mode input that flips during every block are included as well.

// File: rtl/tblk_pkg.sv
package tblk_pkg;
  localparam int BYTE_W = 8;
  localparam int CHK_W  = 16;

  typedef enum logic [1:0] {
    KIND_DATA = 2'b00,
    KIND_ACK  = 2'b10,
    KIND_CTRL = 2'b11
  } blk_kind_e;

  typedef enum logic [1:0] {
    FST_GOOD    = 2'b00,
    FST_BAD_EDC = 2'b01,
    FST_BAD_LEN = 2'b10
  } frm_status_e;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_ADDR,
    PS_CTRL,
    PS_LEN,
    PS_INFO,
    PS_CHK_A,
    PS_CHK_B
  } parse_st_e;
endpackage

// File: rtl/tblk_kind_dec.sv
module tblk_kind_dec
  import tblk_pkg::*;
(
  input  logic [BYTE_W-1:0] ctrl,
  output logic [1:0]        kind
);
  localparam int TOP = BYTE_W - 1;

  always_comb begin
    if (!ctrl[TOP])
      kind = KIND_DATA;
    else if (!ctrl[TOP-1])
      kind = KIND_ACK;
    else
      kind = KIND_CTRL;
  end
endmodule

// File: rtl/tblk_edc.sv
module tblk_edc
  import tblk_pkg::*;
#(
  parameter logic [CHK_W-1:0] POLY = 16'h1021,
  parameter logic [CHK_W-1:0] INIT = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              clr_crc,
  input  logic              run_crc,
  input  logic              upd,
  input  logic [BYTE_W-1:0] din,
  output logic [CHK_W-1:0]  acc
);
  localparam int SHIFT = CHK_W - BYTE_W;

  logic [CHK_W-1:0] acc_d;
  logic [CHK_W-1:0] crc_step;

  always_comb begin
    crc_step = acc ^ ({{SHIFT{1'b0}}, din} << SHIFT);
    for (int b = 0; b < BYTE_W; b++) begin
      if (crc_step[CHK_W-1])
        crc_step = (crc_step << 1) ^ POLY;
      else
        crc_step = crc_step << 1;
    end
  end

  always_comb begin
    acc_d = acc;
    if (clr)
      acc_d = clr_crc ? INIT : '0;
    else if (upd)
      acc_d = run_crc ? crc_step : {acc[CHK_W-1:BYTE_W], acc[BYTE_W-1:0] ^ din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      acc <= '0;
    else if (clr || upd)
      acc <= acc_d;
  end

  AST_EDC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !upd) |=> $stable(acc)); // R12
endmodule

// File: rtl/tblk_parser.sv
module tblk_parser
  import tblk_pkg::*;
#(
  parameter int MAX_INFO = 254
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              edc_sel,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic [CHK_W-1:0]  edc_acc,
  output logic              edc_clr,
  output logic              edc_upd,
  output logic              crc_mode,
  output logic [BYTE_W-1:0] node_addr,
  output logic [BYTE_W-1:0] ctrl_byte,
  output logic              info_valid,
  output logic [BYTE_W-1:0] info_byte,
  output logic              done_pulse,
  output logic [1:0]        done_status
);
  localparam logic [BYTE_W-1:0] MAX_LEN = BYTE_W'(MAX_INFO);

  parse_st_e         st_q, st_d;
  logic [BYTE_W-1:0] remain_q, remain_d;
  logic              crc_d;
  logic              hi_ok_q, hi_ok_d;
  logic [BYTE_W-1:0] addr_d, ctrl_d, info_d;
  logic              info_v_d, done_d;
  logic [1:0]        status_d;
  logic              take;

  assign take    = in_valid && !frame_start;
  assign edc_clr = frame_start;

  always_comb begin
    st_d     = st_q;
    remain_d = remain_q;
    crc_d    = crc_mode;
    hi_ok_d  = hi_ok_q;
    addr_d   = node_addr;
    ctrl_d   = ctrl_byte;
    info_d   = info_byte;
    info_v_d = 1'b0;
    done_d   = 1'b0;
    status_d = done_status;
    edc_upd  = 1'b0;

    if (frame_start) begin
      st_d    = PS_ADDR;
      crc_d   = edc_sel;
      hi_ok_d = 1'b0;
    end else if (take) begin
      unique case (st_q)
        PS_ADDR: begin
          addr_d  = in_byte;
          edc_upd = 1'b1;
          st_d    = PS_CTRL;
        end
        PS_CTRL: begin
          ctrl_d  = in_byte;
          edc_upd = 1'b1;
          st_d    = PS_LEN;
        end
        PS_LEN: begin
          edc_upd = 1'b1;
          if (in_byte > MAX_LEN) begin
            done_d   = 1'b1;
            status_d = FST_BAD_LEN;
            st_d     = PS_IDLE;
          end else if (in_byte == '0) begin
            st_d = PS_CHK_A;
          end else begin
            remain_d = in_byte;
            st_d     = PS_INFO;
          end
        end
        PS_INFO: begin
          edc_upd  = 1'b1;
          info_d   = in_byte;
          info_v_d = 1'b1;
          remain_d = remain_q - 1'b1;
          if (remain_q == 8'd1)
            st_d = PS_CHK_A;
        end
        PS_CHK_A: begin
          if (crc_mode) begin
            hi_ok_d = (in_byte == edc_acc[CHK_W-1:BYTE_W]);
            st_d    = PS_CHK_B;
          end else begin
            done_d   = 1'b1;
            status_d = (in_byte == edc_acc[BYTE_W-1:0]) ? FST_GOOD : FST_BAD_EDC;
            st_d     = PS_IDLE;
          end
        end
        PS_CHK_B: begin
          done_d   = 1'b1;
          status_d = (hi_ok_q && in_byte == edc_acc[BYTE_W-1:0]) ? FST_GOOD : FST_BAD_EDC;
          st_d     = PS_IDLE;
        end
        default: st_d = PS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= PS_IDLE;
      remain_q    <= '0;
      crc_mode    <= 1'b0;
      hi_ok_q     <= 1'b0;
      node_addr   <= '0;
      ctrl_byte   <= '0;
      info_byte   <= '0;
      info_valid  <= 1'b0;
      done_pulse  <= 1'b0;
      done_status <= '0;
    end else begin
      st_q        <= st_d;
      remain_q    <= remain_d;
      crc_mode    <= crc_d;
      hi_ok_q     <= hi_ok_d;
      node_addr   <= addr_d;
      ctrl_byte   <= ctrl_d;
      info_byte   <= info_d;
      info_valid  <= info_v_d;
      done_pulse  <= done_d;
      done_status <= status_d;
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse); // R9
  AST_INFO_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(info_valid && done_pulse)); // R5
  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (done_status != 2'b11)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_IDLE) |=> !info_valid); // R2
  AST_REMAIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_INFO) |-> (remain_q != '0 && remain_q <= MAX_LEN)); // R8
  AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !frame_start) |=> $stable(st_q)); // R12
endmodule

// File: rtl/tblk_receiver.sv
module tblk_receiver
  import tblk_pkg::*;
#(
  parameter int               MAX_INFO = 254,
  parameter logic [15:0]      CRC_POLY = 16'h1021,
  parameter logic [15:0]      CRC_INIT = 16'hFFFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic       edc_sel,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic [7:0] node_addr,
  output logic [7:0] ctrl_byte,
  output logic [1:0] blk_kind,
  output logic       info_valid,
  output logic [7:0] info_byte,
  output logic       done_pulse,
  output logic [1:0] done_status
);
  logic              edc_clr;
  logic              edc_upd;
  logic              crc_mode;
  logic [CHK_W-1:0]  edc_acc;

  tblk_parser #(.MAX_INFO(MAX_INFO)) parse_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .edc_sel     (edc_sel),
    .in_valid    (in_valid),
    .in_byte     (in_byte),
    .edc_acc     (edc_acc),
    .edc_clr     (edc_clr),
    .edc_upd     (edc_upd),
    .crc_mode    (crc_mode),
    .node_addr   (node_addr),
    .ctrl_byte   (ctrl_byte),
    .info_valid  (info_valid),
    .info_byte   (info_byte),
    .done_pulse  (done_pulse),
    .done_status (done_status)
  );

  tblk_edc #(.POLY(CRC_POLY), .INIT(CRC_INIT)) edc_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (edc_clr),
    .clr_crc (edc_sel),
    .run_crc (crc_mode),
    .upd     (edc_upd),
    .din     (in_byte),
    .acc     (edc_acc)
  );

  tblk_kind_dec kind_i (
    .ctrl (ctrl_byte),
    .kind (blk_kind)
  );
endmodule

// File: tb/tblk_receiver_tb_top.sv
module tblk_receiver_tb_top;
  localparam int MAXI = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start = 1'b0;
  logic       edc_sel = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic [7:0] node_addr, ctrl_byte, info_byte;
  logic [1:0] blk_kind, done_status;
  logic       info_valid, done_pulse;

  int nchk = 0;
  int nerr = 0;
  logic [11:0] exp_q[$];
  string       req_q[$];

  always #10 clk = ~clk;

  tblk_receiver #(.MAX_INFO(MAXI)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .edc_sel(edc_sel),
    .in_valid(in_valid), .in_byte(in_byte), .node_addr(node_addr),
    .ctrl_byte(ctrl_byte), .blk_kind(blk_kind), .info_valid(info_valid),
    .info_byte(info_byte), .done_pulse(done_pulse), .done_status(done_status)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] kind_of(logic [7:0] p);
    return p[7] ? p[7:6] : 2'b00;
  endfunction

  function automatic logic [15:0] crc_upd(logic [15:0] c, logic [7:0] d);
    logic [15:0] r = c ^ {d, 8'h00};
    for (int i = 0; i < 8; i++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (info_valid) begin
        if (exp_q.size() == 0) chk("R2/R5", {20'h0, 4'h4, info_byte}, 32'hFFF, "unexpected info");
        else chk(req_q.pop_front(), {20'h0, 4'h4, info_byte}, {20'h0, exp_q.pop_front()}, "info item");
      end
      if (done_pulse) begin
        if (exp_q.size() == 0) chk("R9", {20'h0, 8'h80, done_status, blk_kind}, 32'hFFF, "unexpected done");
        else chk(req_q.pop_front(), {20'h0, 8'h80, done_status, blk_kind}, {20'h0, exp_q.pop_front()}, "done item");
      end
    end
  end

  task automatic put(logic [7:0] b);
    @(negedge clk); in_valid = 1'b1; in_byte = b;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(negedge clk); in_valid = 1'b0; end
  endtask

  task automatic start(logic mode);
    @(negedge clk); in_valid = 1'b0; frame_start = 1'b1; edc_sel = mode;
    @(negedge clk); frame_start = 1'b0;
    edc_sel = ~mode; // R10: later changes must not matter
  endtask

  // corrupt: 0 none, 1 first trailer byte, 2 second trailer byte
  task automatic send_frame(logic mode, logic [7:0] nad, logic [7:0] pcb, logic [7:0] len,
                            logic [7:0] seed, int corrupt, int gap, string req);
    logic [7:0]  body[$];
    logic [7:0]  lrc = 8'h00;
    logic [15:0] crc = 16'hFFFF;
    body.push_back(nad); body.push_back(pcb); body.push_back(len);
    if (len > MAXI) begin
      exp_q.push_back({8'h80, 2'b10, kind_of(pcb)}); req_q.push_back("R8");
    end else begin
      for (int i = 0; i < len; i++) begin
        body.push_back(seed ^ 8'(i * 37));
        exp_q.push_back({4'h4, 8'(seed ^ 8'(i * 37))}); req_q.push_back("R5");
      end
      exp_q.push_back({8'h80, (corrupt != 0) ? 2'b01 : 2'b00, kind_of(pcb)});
      req_q.push_back(req);
    end
    foreach (body[i]) begin lrc ^= body[i]; crc = crc_upd(crc, body[i]); end
    start(mode);
    foreach (body[i]) begin put(body[i]); if (gap > 0) idle(gap); end
    if (len > MAXI) begin
      put(8'h55); put(8'hAA); // R8: ignored after rejection
    end else if (!mode) begin
      put(lrc ^ ((corrupt == 1) ? 8'h01 : 8'h00));
    end else begin
      put(crc[15:8] ^ ((corrupt == 1) ? 8'h80 : 8'h00));
      if (gap > 0) idle(gap);
      put(crc[7:0] ^ ((corrupt == 2) ? 8'h02 : 8'h00));
    end
    idle(3);
    chk("R3", {24'h0, node_addr}, {24'h0, nad}, "node_addr");
    chk("R3", {24'h0, ctrl_byte}, {24'h0, pcb}, "ctrl_byte");
    chk("R4", {30'h0, blk_kind}, {30'h0, kind_of(pcb)}, "blk_kind");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL R9 watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {8'h0, node_addr, ctrl_byte, info_byte}, 32'h0, "bytes in reset");
    chk("R1", {26'h0, blk_kind, info_valid, done_pulse, done_status}, 32'h0, "flags in reset");
    rst_n = 1'b1;
    idle(2);
    // R2: stray bytes before any frame_start
    put(8'hC3); put(8'h11); put(8'h02); put(8'h99); idle(3);
    chk("R2", {16'h0, node_addr, ctrl_byte}, 32'h0, "prologue untouched");
    send_frame(1'b0, 8'h12, 8'h05, 8'd5, 8'h3C, 0, 0, "R6");   // data block, good XOR
    send_frame(1'b0, 8'h21, 8'h91, 8'd0, 8'h00, 0, 0, "R11");  // ack block, empty
    send_frame(1'b0, 8'h07, 8'hC1, 8'd3, 8'hA5, 1, 0, "R6");   // ctrl block, bad XOR
    send_frame(1'b1, 8'h00, 8'h40, 8'd16, 8'h5A, 0, 0, "R7");  // max length, good CRC
    send_frame(1'b1, 8'hFF, 8'h80, 8'd2, 8'h01, 1, 0, "R7");   // bad CRC high
    send_frame(1'b1, 8'h34, 8'hE0, 8'd4, 8'h77, 2, 0, "R7");   // bad CRC low
    send_frame(1'b1, 8'h44, 8'h00, 8'd0, 8'h00, 0, 0, "R11");  // CRC over prologue only
    send_frame(1'b0, 8'h56, 8'hC2, 8'd17, 8'h00, 0, 0, "R8");  // above MAX_INFO
    send_frame(1'b1, 8'h65, 8'h83, 8'd255, 8'h00, 0, 0, "R8"); // always rejected
    // R2: bytes after a closed block are ignored
    put(8'h01); put(8'h02); put(8'h03); idle(3);
    chk("R2", {16'h0, node_addr, ctrl_byte}, {16'h0, 8'h65, 8'h83}, "after close");
    // R10: abort mid-block, no done
    start(1'b1);
    put(8'h70); put(8'h00); put(8'd4); put(8'hEE);
    exp_q.push_back({4'h4, 8'hEE}); req_q.push_back("R10");
    send_frame(1'b0, 8'h71, 8'h8F, 8'd3, 8'h19, 0, 0, "R10");
    send_frame(1'b1, 8'h72, 8'h11, 8'd6, 8'hC8, 0, 2, "R12"); // gaps, CRC
    send_frame(1'b0, 8'h73, 8'hD0, 8'd7, 8'h2E, 0, 1, "R12"); // gaps, XOR
    idle(5);
    chk("R9", exp_q.size(), 0, "missing results");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule